// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block lets software bit-bang an external one-wire-data serial EEPROM through a single byte-wide control register, while the memory port those pins live on is shared with other requesters. Software sets a request bit and waits. Once the shared port reports that it is idle, the block takes ownership. From then on it drives the chip-select, serial-clock and data-out bits of the register onto the EEPROM pins. The EEPROM's data-in line is sampled into the register every cycle.

A ready bit in the same register serves two purposes. It first rises to acknowledge the grant, with no delay implied. After that, every register write made while the port is owned drops the bit. The bit rises again after a fixed settle time of 800 ns, expressed in clock cycles as ceil(800 ns × CLK_HZ). Software paces each EEPROM clock edge by polling this bit. Writing the register with the request bit clear gives the port back at once. The EEPROM command protocol itself is left to software.

Top module: `eep_port_arbiter`

## Requirements
- R1: After reset every register bit reads 0, the port is not owned, and the chip-select, clock and data-out pins are low.
- R2: Register read layout: bit 5 request, bit 4 ready (read-only), bit 3 chip select, bit 2 serial clock, bit 1 data out, bit 0 sampled data-in, bits 7:6 read 0. Bits 5, 3, 2 and 1 read back the value last written to them.
- R3: While port_busy is high and the port is not yet owned, a pending request is not granted and ready stays 0.
- R4: A pending request is granted on the first clock edge at which port_busy is low. Ready rises on that same edge, with no settle delay, so it reads 1 one cycle after the request write when the port is idle.
- R5: While the port is owned, ee_cs, ee_sk and ee_do follow register bits 3, 2 and 1. While it is not owned, all three are held low whatever those bits hold.
- R6: A write with bit 5 set while the port is owned clears ready on its clock edge. Ready rises exactly SETTLE_CYC = ceil(800 × CLK_HZ / 10^9) edges after that write.
- R7: A further owning write made while a settle period is running restarts the full SETTLE_CYC count from that write.
- R8: A write with bit 5 clear releases the port on its clock edge. Ready reads 0 and the pins go low on that edge, also when a settle period is running.
- R9: The level on ee_di appears in register bit 0 one clock edge later.
- R10: Once the port is owned, port_busy has no effect. Ownership, pin drive and the ready sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| port_busy | input | 1 | Shared memory port in use by another requester |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Data to the EEPROM |
| ee_di | input | 1 | Data from the EEPROM |

## Verification
The hardest situation to reach is a settle period that is cut short, either by a second owning write or by a release. Both must land strictly inside the SETTLE_CYC window. The bench runs with a clock frequency that makes the 800 ns window a non-integer number of cycles, which exercises the rounding up. It counts edges from each write exactly, issues the interrupting write partway through the window, and then checks ready cycle by cycle against the restarted count or against the release. Grant blocking is reached by holding port_busy high before the request is written, then dropping it on a known cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BIT_REQ   = 5;
  localparam int BIT_READY = 4;
  localparam int BIT_CS    = 3;
  localparam int BIT_SK    = 2;
  localparam int BIT_DO    = 1;
  localparam int BIT_DI    = 0;
  localparam longint SETTLE_NS = 800;

  // cycles = ceil(SETTLE_NS * hz / 1e9)
  function automatic int settle_cycles(input longint hz);
    longint prod;
    prod = SETTLE_NS * hz;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/eep_grant_ctrl.sv
module eep_grant_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_pending,
  input  logic release_evt,
  input  logic port_busy,
  output logic granted,
  output logic grant_evt
);
  assign grant_evt = req_pending & ~granted & ~port_busy & ~release_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           granted <= 1'b0;
    else if (release_evt) granted <= 1'b0;
    else if (grant_evt)   granted <= 1'b1;
  end
endmodule

// File: rtl/eep_settle_timer.sv
module eep_settle_timer #(
  parameter int SETTLE_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_evt,
  input  logic restart_evt,
  input  logic release_evt,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      ready  <= 1'b0;
    end else if (release_evt) begin
      remain <= '0;
      ready  <= 1'b0;
    end else if (restart_evt) begin
      remain <= LOAD;
      ready  <= 1'b0;
    end else if (grant_evt) begin
      remain <= '0;
      ready  <= 1'b1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
      if (remain == CW'(1)) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/eep_port_arbiter.sv
module eep_port_arbiter #(
  parameter longint CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       port_busy,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_do,
  input  logic       ee_di
);
  import eep_pkg::*;

  localparam int SETTLE_CYC = settle_cycles(CLK_HZ);

  logic req_q, cs_q, sk_q, do_q, di_q;
  logic granted, grant_evt, ready;
  logic release_evt, restart_evt;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[BIT_READY], reg_wdata[BIT_DI]};

  assign release_evt = reg_wr & ~reg_wdata[BIT_REQ];
  assign restart_evt = reg_wr &  reg_wdata[BIT_REQ] & granted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cs_q  <= 1'b0;
      sk_q  <= 1'b0;
      do_q  <= 1'b0;
      di_q  <= 1'b0;
    end else begin
      di_q <= ee_di;
      if (reg_wr) begin
        req_q <= reg_wdata[BIT_REQ];
        cs_q  <= reg_wdata[BIT_CS];
        sk_q  <= reg_wdata[BIT_SK];
        do_q  <= reg_wdata[BIT_DO];
      end
    end
  end

  eep_grant_ctrl u_grant (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_pending (req_q),
    .release_evt (release_evt),
    .port_busy   (port_busy),
    .granted     (granted),
    .grant_evt   (grant_evt)
  );

  eep_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_evt   (grant_evt),
    .restart_evt (restart_evt),
    .release_evt (release_evt),
    .ready       (ready)
  );

  assign ee_cs = granted & cs_q;
  assign ee_sk = granted & sk_q;
  assign ee_do = granted & do_q;

  always_comb begin
    reg_rdata            = '0;
    reg_rdata[BIT_REQ]   = req_q;
    reg_rdata[BIT_READY] = ready;
    reg_rdata[BIT_CS]    = cs_q;
    reg_rdata[BIT_SK]    = sk_q;
    reg_rdata[BIT_DO]    = do_q;
    reg_rdata[BIT_DI]    = di_q;
  end
endmodule

// File: rtl/eep_port_arbiter_chk.sv
module eep_port_arbiter_chk #(
  parameter longint CLK_HZ = 100_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic req_bit,
  input logic port_busy,
  input logic granted,
  input logic ready,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_do
);
  localparam int S  = eep_pkg::settle_cycles(CLK_HZ);
  localparam int CW = $clog2(S + 2) + 1;

  logic          settling;
  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settling <= 1'b0;
      since    <= '0;
    end else if (reg_wr && req_bit && granted) begin
      settling <= 1'b1;
      since    <= CW'(1);
    end else if (reg_wr && !req_bit) begin
      settling <= 1'b0;
    end else if (settling) begin
      if (ready) settling <= 1'b0;
      else       since <= since + 1'b1;
    end
  end

  // R5
  pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !granted |-> (!ee_cs && !ee_sk && !ee_do));

  // R3
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(!port_busy));

  // R4
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> ready);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !req_bit) |=> (!granted && !ready));

  // R6
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && req_bit && granted) |=> !ready);

  // R6
  settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (ready == (since > CW'(S))));

  // R10
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && !reg_wr) |=> granted);
endmodule

bind eep_port_arbiter eep_port_arbiter_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .req_bit   (reg_wdata[5]),
  .port_busy (port_busy),
  .granted   (granted),
  .ready     (ready),
  .ee_cs     (ee_cs),
  .ee_sk     (ee_sk),
  .ee_do     (ee_do)
);

// File: tb/eep_port_arbiter_tb.sv
module eep_port_arbiter_tb;
  localparam time CLK_PERIOD = 10ns;
  // 33 MHz: 800 ns * 33e6 = 26.4 cycles, rounded up to 27
  localparam longint TB_HZ = 33_000_000;
  localparam int EXP_SETTLE = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic port_busy = 1'b0;
  logic ee_cs, ee_sk, ee_do;
  logic ee_di = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eep_port_arbiter #(.CLK_HZ(TB_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .port_busy(port_busy), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ready_of(input logic [7:0] r);
    return {7'b0, r[4]};
  endfunction

  function automatic logic [7:0] pins();
    return {5'b0, ee_cs, ee_sk, ee_do};
  endfunction

  // called at a negedge; returns at the negedge after the write edge
  task automatic reg_write(input logic [7:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 pins", pins(), 8'h00);
  endtask

  task automatic t_unowned_pins();
    reg_write(8'h0E);
    check("R2 readback", reg_rdata, 8'h0E);
    check("R5 pins held low", pins(), 8'h00);
    reg_write(8'hC0);
    check("R2 top bits read 0", reg_rdata, 8'h00);
  endtask

  task automatic t_busy_then_grant();
    port_busy = 1'b1;
    reg_write(8'h28);
    for (int i = 0; i < 5; i++) begin
      check("R3 no grant while busy", ready_of(reg_rdata), 8'h00);
      check("R3 pins low while busy", pins(), 8'h00);
      @(negedge clk);
    end
    port_busy = 1'b0;
    @(negedge clk);
    check("R4 ready at grant", ready_of(reg_rdata), 8'h01);
    check("R5 cs after grant", pins(), 8'h04);
  endtask

  task automatic t_settle();
    reg_write(8'h2A);
    check("R6 ready cleared", ready_of(reg_rdata), 8'h00);
    check("R5 pins follow", pins(), 8'h05);
    for (int i = 1; i < EXP_SETTLE; i++) @(negedge clk);
    check("R6 ready low at N-1", ready_of(reg_rdata), 8'h00);
    @(negedge clk);
    check("R6 ready high at N", ready_of(reg_rdata), 8'h01);
  endtask

  task automatic t_restart();
    reg_write(8'h2C);
    for (int i = 0; i < 10; i++) @(negedge clk);
    reg_write(8'h28);
    for (int i = 1; i < EXP_SETTLE; i++) @(negedge clk);
    check("R7 ready low before restarted end", ready_of(reg_rdata), 8'h00);
    @(negedge clk);
    check("R7 ready at restarted end", ready_of(reg_rdata), 8'h01);
  endtask

  task automatic t_no_preempt();
    port_busy = 1'b1;
    reg_write(8'h26);
    check("R10 pins driven while busy", pins(), 8'h03);
    for (int i = 1; i < EXP_SETTLE; i++) @(negedge clk);
    @(negedge clk);
    check("R10 ready sequence while busy", ready_of(reg_rdata), 8'h01);
    port_busy = 1'b0;
  endtask

  task automatic t_data_in();
    ee_di = 1'b1;
    @(negedge clk);
    check("R9 di high", {7'b0, reg_rdata[0]}, 8'h01);
    ee_di = 1'b0;
    @(negedge clk);
    check("R9 di low", {7'b0, reg_rdata[0]}, 8'h00);
  endtask

  task automatic t_release_in_settle();
    reg_write(8'h2E);
    for (int i = 0; i < 5; i++) @(negedge clk);
    reg_write(8'h0E);
    check("R8 ready dropped", ready_of(reg_rdata), 8'h00);
    check("R8 pins low", pins(), 8'h00);
    check("R8 req reads 0", {7'b0, reg_rdata[5]}, 8'h00);
    for (int i = 0; i < EXP_SETTLE + 3; i++) @(negedge clk);
    check("R8 no late ready", ready_of(reg_rdata), 8'h00);
    reg_write(8'h20);
    @(negedge clk);
    check("R4 regrant immediate", ready_of(reg_rdata), 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unowned_pins();
    t_busy_then_grant();
    t_settle();
    t_restart();
    t_no_preempt();
    t_data_in();
    t_release_in_settle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule